// File: doc/BRIEF.md
# Page Access Permission Checker

This block rules on a single memory access once a two-level page walk has finished. It receives the access kind (user or supervisor privilege, and one of read, write or fetch), the writable, user and no-execute bits of both the directory entry and the table entry, and the outcome flags of the walk (entry absent, reserved bit set). It also receives the processor controls: no-execute enable, supervisor write protection, supervisor-execution prevention and protection-key enable. The page's 4-bit protection key and a 32-bit key-rights word complete the inputs. From these it forms a fault flag and a 6-bit error code in the standard page-fault layout.

The decision is purely combinational and is captured into output registers on a request strobe. A pipeline stage places the checker after the walker: it samples the request in one cycle and presents the verdict in the next. Between requests the registered verdict is held. A request that asks for a write and a fetch together is reported as malformed rather than judged.

Top module: `pac_checker`

## Requirements
- R1: When `req_valid` is high at a rising clock edge, `rsp_valid` is high after that edge and `rsp_fault`, `rsp_code` and `rsp_illegal` show the verdict for the sampled inputs. When `req_valid` is low, `rsp_valid` falls and the other three outputs keep their values. Reset clears all four outputs.
- R2: The effective writable right is the AND of the directory and table writable bits. The effective user right is the AND of both user bits. The page is non-executable when either level's no-execute bit is set and `ctl_nxe` is 1.
- R3: If `walk_absent` is 1, the access faults with code bit 0 clear and bit 3 clear, even when `walk_rsvd` is also 1.
- R4: If `walk_rsvd` is 1 and `walk_absent` is 0, the access faults with code bits 0 and 3 set.
- R5: A user-privilege access (`acc_user`=1) to a page whose effective user right is 0 faults. A user access to a page with the effective user right set does not fault for that reason.
- R6: A write to a page whose effective writable right is 0 faults, with one exception: a supervisor write with `ctl_wp`=0 is allowed.
- R7: A fetch from a non-executable page faults. The no-execute bits have no effect while `ctl_nxe` is 0.
- R8: With `ctl_smep`=1, a supervisor fetch from a page whose effective user right is 1 faults.
- R9: With `ctl_pke`=1, a non-fetch access to a page whose effective user right is 1 faults when the access-disable bit of key n, at bit 2n of `key_rights`, is set. A key fault sets code bit 5. Fetches, non-user pages and `ctl_pke`=0 are never key faults.
- R10: Under the same conditions as R9, the write-disable bit of key n, at bit 2n+1 of `key_rights`, faults writes, except a supervisor write while `ctl_wp`=0.
- R11: Code bit 4 mirrors `acc_fetch` only when `ctl_nxe` or `ctl_smep` is 1. Otherwise it is 0.
- R12: On a fault, code bit 1 is `acc_write` and bit 2 is `acc_user`. Bit 0 is set for every fault except one caused by an absent entry. When there is no fault, the whole code is 0.
- R13: A request with `acc_write` and `acc_fetch` both 1 sets `rsp_illegal` and gives `rsp_fault`=0 and `rsp_code`=0. Any legal request clears `rsp_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs sampled on this edge |
| acc_user | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| dir_wr | input | 1 | Directory entry writable bit |
| dir_usr | input | 1 | Directory entry user bit |
| dir_nx | input | 1 | Directory entry no-execute bit |
| tbl_wr | input | 1 | Table entry writable bit |
| tbl_usr | input | 1 | Table entry user bit |
| tbl_nx | input | 1 | Table entry no-execute bit |
| walk_absent | input | 1 | Walk hit a non-present entry |
| walk_rsvd | input | 1 | Walk hit a reserved-bit violation |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_wp | input | 1 | Supervisor write protection |
| ctl_smep | input | 1 | Supervisor-execution prevention |
| ctl_pke | input | 1 | Protection-key enable |
| page_key | input | 4 | Page protection key |
| key_rights | input | 32 | Per-key access-disable / write-disable pairs |
| rsp_valid | output | 1 | Verdict presented this cycle |
| rsp_fault | output | 1 | Access faults |
| rsp_code | output | 6 | Error code: bit0 protection, bit1 write, bit2 user, bit3 reserved, bit4 fetch, bit5 key |
| rsp_illegal | output | 1 | Request had both write and fetch set |

## Verification
The assertions take for granted that the request inputs are stable around the sampling edge. They also assume that `walk_absent` and `walk_rsvd` mean what the walker intends, so an absent entry may also carry a stray reserved flag. The bench changes every input only at falling edges and pulses `req_valid` for exactly one cycle. Each verdict is therefore tied to one sampled set of inputs. The bench deliberately drives both absent and reserved together, and also write and fetch together, to show the stated priority. It then sweeps pseudo-random legal and illegal combinations against a model written from the requirements.

// File: rtl/pac_pkg.sv
package pac_pkg;

  localparam int CODE_W = 6;

  // Error code bit positions (decoded by the fault handler)
  localparam int EC_P = 0;
  localparam int EC_W = 1;
  localparam int EC_U = 2;
  localparam int EC_R = 3;
  localparam int EC_I = 4;
  localparam int EC_K = 5;

  typedef logic [CODE_W-1:0] pac_code_t;

  typedef struct packed {
    logic user;
    logic write;
    logic fetch;
  } pac_access_t;

  typedef struct packed {
    logic nxe;
    logic wp;
    logic smep;
    logic pke;
  } pac_ctl_t;

  typedef struct packed {
    logic wr;
    logic usr;
    logic xd;
  } pac_rights_t;

  typedef struct packed {
    logic      illegal;
    logic      fault;
    pac_code_t code;
  } pac_verdict_t;

endpackage

// File: rtl/pac_rights_merge.sv
module pac_rights_merge
  import pac_pkg::*;
#(
  parameter int LEVELS = 2
) (
  input  logic [LEVELS-1:0] lvl_wr,
  input  logic [LEVELS-1:0] lvl_usr,
  input  logic [LEVELS-1:0] lvl_nx,
  input  logic              nxe,
  output pac_rights_t       eff
);

  // Rights narrow as the walk descends: a right holds only if every level grants it.
  always_comb begin
    eff.wr  = &lvl_wr;
    eff.usr = &lvl_usr;
    eff.xd  = nxe & (|lvl_nx);
  end

endmodule

// File: rtl/pac_key_lookup.sv
module pac_key_lookup #(
  parameter int KEY_BITS = 4,
  localparam int NUM_KEYS = 1 << KEY_BITS,
  localparam int RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic [KEY_BITS-1:0] key,
  input  logic [RIGHTS_W-1:0] rights,
  output logic                acc_dis,
  output logic                wr_dis
);

  logic [NUM_KEYS-1:0] ad_vec;
  logic [NUM_KEYS-1:0] wd_vec;

  // Each key owns an adjacent pair: access-disable low, write-disable high.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign ad_vec[k] = rights[2*k];
    assign wd_vec[k] = rights[2*k+1];
  end

  assign acc_dis = ad_vec[key];
  assign wr_dis  = wd_vec[key];

endmodule

// File: rtl/pac_decide.sv
module pac_decide
  import pac_pkg::*;
(
  input  pac_access_t  acc,
  input  pac_rights_t  eff,
  input  pac_ctl_t     ctl,
  input  logic         key_ad,
  input  logic         key_wd,
  input  logic         absent,
  input  logic         rsvd,
  output pac_verdict_t verdict
);

  logic      sup_wr_ok;
  logic      f_usr;
  logic      f_wr;
  logic      f_exec;
  logic      f_smep;
  logic      key_scope;
  logic      f_key;
  logic      f_perm;
  pac_code_t base;

  always_comb begin
    // Supervisor writes ignore read-only pages while write protection is off.
    sup_wr_ok = ~ctl.wp & ~acc.user;

    f_usr  = acc.user & ~eff.usr;
    f_wr   = acc.write & ~eff.wr & ~sup_wr_ok;
    f_exec = acc.fetch & eff.xd;
    f_smep = acc.fetch & ~acc.user & eff.usr & ctl.smep;

    key_scope = eff.usr & ~acc.fetch & ctl.pke;
    f_key     = key_scope & (key_ad | (acc.write & key_wd & ~sup_wr_ok));

    f_perm = f_usr | f_wr | f_exec | f_smep | f_key;

    base       = '0;
    base[EC_W] = acc.write;
    base[EC_U] = acc.user;
    base[EC_I] = acc.fetch & (ctl.nxe | ctl.smep);

    verdict.illegal = acc.write & acc.fetch;
    verdict.fault   = 1'b0;
    verdict.code    = '0;

    if (verdict.illegal) begin
      verdict.fault = 1'b0;
      verdict.code  = '0;
    end else if (absent) begin
      verdict.fault = 1'b1;
      verdict.code  = base;
    end else if (rsvd) begin
      verdict.fault      = 1'b1;
      verdict.code       = base;
      verdict.code[EC_P] = 1'b1;
      verdict.code[EC_R] = 1'b1;
    end else if (f_perm) begin
      verdict.fault      = 1'b1;
      verdict.code       = base;
      verdict.code[EC_P] = 1'b1;
      verdict.code[EC_K] = f_key;
    end
  end

endmodule

// File: rtl/pac_checker.sv
module pac_checker
  import pac_pkg::*;
#(
  parameter int KEY_BITS = 4,
  localparam int LEVELS   = 2,
  localparam int RIGHTS_W = 2 * (1 << KEY_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                acc_user,
  input  logic                acc_write,
  input  logic                acc_fetch,
  input  logic                dir_wr,
  input  logic                dir_usr,
  input  logic                dir_nx,
  input  logic                tbl_wr,
  input  logic                tbl_usr,
  input  logic                tbl_nx,
  input  logic                walk_absent,
  input  logic                walk_rsvd,
  input  logic                ctl_nxe,
  input  logic                ctl_wp,
  input  logic                ctl_smep,
  input  logic                ctl_pke,
  input  logic [KEY_BITS-1:0] page_key,
  input  logic [RIGHTS_W-1:0] key_rights,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [CODE_W-1:0]   rsp_code,
  output logic                rsp_illegal
);

  pac_access_t  acc;
  pac_ctl_t     ctl;
  pac_rights_t  eff;
  pac_verdict_t verdict;
  pac_verdict_t vd_q;
  pac_verdict_t vd_d;
  logic         valid_d;
  logic         key_ad;
  logic         key_wd;

  assign acc = '{user: acc_user, write: acc_write, fetch: acc_fetch};
  assign ctl = '{nxe: ctl_nxe, wp: ctl_wp, smep: ctl_smep, pke: ctl_pke};

  pac_rights_merge #(.LEVELS(LEVELS)) u_merge (
    .lvl_wr  ({dir_wr,  tbl_wr}),
    .lvl_usr ({dir_usr, tbl_usr}),
    .lvl_nx  ({dir_nx,  tbl_nx}),
    .nxe     (ctl_nxe),
    .eff     (eff)
  );

  pac_key_lookup #(.KEY_BITS(KEY_BITS)) u_keys (
    .key     (page_key),
    .rights  (key_rights),
    .acc_dis (key_ad),
    .wr_dis  (key_wd)
  );

  pac_decide u_decide (
    .acc     (acc),
    .eff     (eff),
    .ctl     (ctl),
    .key_ad  (key_ad),
    .key_wd  (key_wd),
    .absent  (walk_absent),
    .rsvd    (walk_rsvd),
    .verdict (verdict)
  );

  // Next-state: the verdict register loads only on a request strobe.
  always_comb begin
    valid_d = req_valid;
    vd_d    = vd_q;
    if (req_valid) begin
      vd_d = verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      vd_q      <= '0;
    end else begin
      rsp_valid <= valid_d;
      vd_q      <= vd_d;
    end
  end

  assign rsp_fault   = vd_q.fault;
  assign rsp_code    = vd_q.code;
  assign rsp_illegal = vd_q.illegal;

  // R1: a strobe yields a response strobe on the next cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1: verdict holds while no request is sampled
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_fault) && $stable(rsp_code) && $stable(rsp_illegal)));

  // R13: a malformed request never carries a fault
  a_r13_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (!rsp_fault && rsp_code == '0));

  // R12: no fault means an all-zero code
  a_r12_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> rsp_code == '0);

  // R4: a reserved-bit report always marks a present entry
  a_r4_rsvd_present: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_code[EC_R] |-> rsp_code[EC_P]);

  // R9: key faults cannot appear with key checking off
  a_r9_key_needs_pke: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ctl_pke) |=> !rsp_code[EC_K]);

  // R11: fetch bit stays clear unless no-execute or SMEP is enabled
  a_r11_fetch_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ctl_nxe && !ctl_smep) |=> !rsp_code[EC_I]);

  // R3: an absent entry always faults
  a_r3_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && walk_absent && !(acc_write && acc_fetch)) |=> (rsp_fault && !rsp_code[EC_P]));

endmodule

// File: tb/pac_checker_tb.sv
`timescale 1ns/100ps
module pac_checker_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        acc_user, acc_write, acc_fetch;
  logic        dir_wr, dir_usr, dir_nx, tbl_wr, tbl_usr, tbl_nx;
  logic        walk_absent, walk_rsvd;
  logic        ctl_nxe, ctl_wp, ctl_smep, ctl_pke;
  logic [3:0]  page_key;
  logic [31:0] key_rights;
  logic        rsp_valid, rsp_fault, rsp_illegal;
  logic [5:0]  rsp_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pac_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .acc_user(acc_user), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .dir_wr(dir_wr), .dir_usr(dir_usr), .dir_nx(dir_nx),
    .tbl_wr(tbl_wr), .tbl_usr(tbl_usr), .tbl_nx(tbl_nx),
    .walk_absent(walk_absent), .walk_rsvd(walk_rsvd),
    .ctl_nxe(ctl_nxe), .ctl_wp(ctl_wp), .ctl_smep(ctl_smep), .ctl_pke(ctl_pke),
    .page_key(page_key), .key_rights(key_rights),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_illegal(rsp_illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid/ill/flt/code=%b expected %b", req, act, exp);
    end
  endtask

  task automatic defaults();
    req_valid = 0; acc_user = 0; acc_write = 0; acc_fetch = 0;
    dir_wr = 1; dir_usr = 1; dir_nx = 0; tbl_wr = 1; tbl_usr = 1; tbl_nx = 0;
    walk_absent = 0; walk_rsvd = 0;
    ctl_nxe = 0; ctl_wp = 0; ctl_smep = 0; ctl_pke = 0;
    page_key = 0; key_rights = 0;
  endtask

  // Pulse one request at a falling edge, inspect the registered verdict one cycle later.
  task automatic issue(string req, logic e_ill, logic e_flt, logic [5:0] e_code);
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(req, {rsp_valid, rsp_illegal, rsp_fault, rsp_code}, {1'b1, e_ill, e_flt, e_code});
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", {rsp_valid, rsp_illegal, rsp_fault, rsp_code}, 9'b0);
    rst_n = 1;
  endtask

  task automatic t_rights_merge();
    defaults(); acc_user = 1; tbl_usr = 0;
    issue("R2 user and", 0, 1, 6'd5);
    defaults(); acc_user = 1; acc_write = 1; dir_wr = 0;
    issue("R2 write and", 0, 1, 6'd7);
    defaults(); acc_fetch = 1; tbl_usr = 0; dir_nx = 1; ctl_nxe = 1;
    issue("R2 nx either level", 0, 1, 6'd17);
  endtask

  task automatic t_absent();
    defaults(); acc_user = 1; acc_write = 1; walk_absent = 1; walk_rsvd = 1;
    issue("R3 absent over reserved", 0, 1, 6'd6);
  endtask

  task automatic t_reserved();
    defaults(); walk_rsvd = 1;
    issue("R4 reserved", 0, 1, 6'd9);
    defaults(); acc_user = 1; acc_write = 1; walk_rsvd = 1;
    issue("R12 reserved user write", 0, 1, 6'd15);
  endtask

  task automatic t_user();
    defaults(); acc_user = 1;
    issue("R5 user page ok", 0, 0, 6'd0);
    defaults(); acc_user = 1; dir_usr = 0;
    issue("R5 supervisor page", 0, 1, 6'd5);
  endtask

  task automatic t_write();
    defaults(); acc_write = 1; tbl_wr = 0;
    issue("R6 sup write wp off", 0, 0, 6'd0);
    defaults(); acc_write = 1; tbl_wr = 0; ctl_wp = 1;
    issue("R6 sup write wp on", 0, 1, 6'd3);
    defaults(); acc_user = 1; acc_write = 1; tbl_wr = 0;
    issue("R6 user write ro", 0, 1, 6'd7);
  endtask

  task automatic t_fetch_nx();
    defaults(); acc_fetch = 1; tbl_usr = 0; tbl_nx = 1; ctl_nxe = 1;
    issue("R7 nx fetch", 0, 1, 6'd17);
    defaults(); acc_fetch = 1; tbl_usr = 0; tbl_nx = 1;
    issue("R7 nx ignored", 0, 0, 6'd0);
  endtask

  task automatic t_smep();
    defaults(); acc_fetch = 1; ctl_smep = 1;
    issue("R8 smep fault", 0, 1, 6'd17);
    defaults(); acc_fetch = 1; tbl_usr = 0; ctl_smep = 1;
    issue("R8 kernel page", 0, 0, 6'd0);
    defaults(); acc_user = 1; acc_fetch = 1; ctl_smep = 1;
    issue("R8 user fetch", 0, 0, 6'd0);
  endtask

  task automatic t_key_ad();
    defaults(); ctl_pke = 1; page_key = 4'd5; key_rights = 32'h0000_0400;
    issue("R9 ad hit", 0, 1, 6'd33);
    page_key = 4'd4;
    issue("R9 other key", 0, 0, 6'd0);
    page_key = 4'd5; acc_fetch = 1;
    issue("R9 fetch exempt", 0, 0, 6'd0);
    acc_fetch = 0; ctl_pke = 0;
    issue("R9 pke off", 0, 0, 6'd0);
    ctl_pke = 1; dir_usr = 0;
    issue("R9 kernel page", 0, 0, 6'd0);
  endtask

  task automatic t_key_wd();
    defaults(); ctl_pke = 1; page_key = 4'd3; key_rights = 32'h0000_0080;
    acc_user = 1; acc_write = 1;
    issue("R10 user write", 0, 1, 6'd39);
    acc_user = 0;
    issue("R10 sup write wp off", 0, 0, 6'd0);
    ctl_wp = 1;
    issue("R10 sup write wp on", 0, 1, 6'd35);
    acc_write = 0;
    issue("R10 read ok", 0, 0, 6'd0);
  endtask

  task automatic t_fetch_report();
    defaults(); acc_user = 1; acc_fetch = 1; dir_usr = 0;
    issue("R11 fetch bit masked", 0, 1, 6'd5);
    ctl_nxe = 1;
    issue("R11 fetch bit nxe", 0, 1, 6'd21);
    defaults(); acc_fetch = 1; walk_absent = 1; ctl_smep = 1;
    issue("R11 fetch bit smep absent", 0, 1, 6'd16);
  endtask

  task automatic t_illegal();
    defaults(); acc_write = 1; acc_fetch = 1; walk_absent = 1;
    issue("R13 write+fetch", 1, 0, 6'd0);
    defaults();
    issue("R13 cleared", 0, 0, 6'd0);
  endtask

  task automatic t_hold();
    defaults(); acc_user = 1; tbl_usr = 0;
    issue("R1 load", 0, 1, 6'd5);
    tbl_usr = 1; acc_write = 1; walk_rsvd = 1;
    repeat (3) @(negedge clk);
    check("R1 hold", {rsp_valid, rsp_illegal, rsp_fault, rsp_code}, {1'b0, 1'b0, 1'b1, 6'd5});
  endtask

  function automatic logic [7:0] model();
    logic [5:0] c;
    logic uw, ww, xd, sok, kf, pf;
    if (acc_write && acc_fetch) return 8'h80;
    c = {1'b0, acc_fetch && (ctl_nxe || ctl_smep), 1'b0, acc_user, acc_write, 1'b0};
    if (walk_absent) return {2'b01, c};
    if (walk_rsvd) return {2'b01, c | 6'b001001};
    uw  = dir_usr && tbl_usr;
    ww  = dir_wr && tbl_wr;
    xd  = ctl_nxe && (dir_nx || tbl_nx);
    sok = !acc_user && !ctl_wp;
    kf  = uw && !acc_fetch && ctl_pke &&
          (key_rights[2*page_key] || (acc_write && key_rights[2*page_key+1] && !sok));
    pf  = (acc_user && !uw) || (acc_write && !ww && !sok) || (acc_fetch && xd) ||
          (acc_fetch && !acc_user && uw && ctl_smep) || kf;
    if (!pf) return 8'h00;
    return {2'b01, c | {kf, 5'b00001}};
  endfunction

  task automatic t_sweep();
    logic [7:0] e;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      {acc_user, acc_write, acc_fetch, dir_wr, dir_usr, dir_nx, tbl_wr, tbl_usr} = $urandom;
      {tbl_nx, walk_absent, walk_rsvd, ctl_nxe, ctl_wp, ctl_smep, ctl_pke, page_key} = $urandom;
      walk_absent = walk_absent & ($urandom_range(0, 3) == 0);
      walk_rsvd   = walk_rsvd & ($urandom_range(0, 3) == 0);
      key_rights  = $urandom;
      e = model();
      issue("R12 sweep", e[7], e[6], e[5:0]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rights_merge();
    t_absent();
    t_reserved();
    t_user();
    t_write();
    t_fetch_nx();
    t_smep();
    t_key_ad();
    t_key_wd();
    t_fetch_report();
    t_illegal();
    t_hold();
    t_sweep();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule